// File: doc/BRIEF.md
# Shared ROM/SRAM External Memory Bus Controller

This block turns word read and write requests from one internal requester into bus cycles on a single external memory bus. Two devices share that bus: a ROM that is always 16 bits wide and a static RAM that may be 16 or 8 bits wide. Each request carries a target flag that picks the ROM or the RAM, a 19-bit word address and, for writes, a 16-bit word. The controller drives the address, the active-low selects and strobes, and the outgoing data with its drive enable. It returns read data together with a one-clock completion pulse.

The RAM width is set by a static mode input. In narrow mode every RAM word access becomes two byte accesses inside one word cycle. A byte-select output serves as the lowest RAM address bit: low for the low byte, high for the high byte. Data travels on bits [7:0] only. All pulse widths are counted in clocks. With the default 26.042 ns clock, a wide access takes 5 clocks (about 130 ns) and a narrow RAM access takes 7 clocks. The requester holds its request until the completion pulse. A new request is taken in the clock after that pulse.

Top module: `shmem_bus_ctrl`

## Requirements
- R1: While reset is held and right after it: both selects, the read strobe and the write strobe are high, the data drive enable is 0, byte select is 0 and done is 0.
- R2: A 16-bit read (ROM, or RAM in wide mode) returns the word present on the input data bus while the read strobe is low. Done is a single-clock pulse 5 clocks after the clock where the request is first seen while idle.
- R3: Target flag 0 lowers only the ROM select and flag 1 lowers only the RAM select. The two selects are never low together, and the address stays stable while a select is low.
- R4: The read and write strobes are never low together. Neither falls until its select has been low for at least SETUP_CLKS (default 2) clocks.
- R5: The data drive enable is high only during RAM writes and only while the read strobe is high. It is released in the last clock of the cycle, while the select is still low.
- R6: A RAM read in narrow mode (mode input 1) reads the low byte with byte select 0, then the high byte with byte select 1, each from data bits [7:0]. It ignores bits [15:8], returns {high, low}, and raises done 7 clocks after acceptance.
- R7: A RAM write in narrow mode gives exactly two separate write strobe pulses. The first has byte select 0 and data {8'h00, word[7:0]}. The second has byte select 1 and data {8'h00, word[15:8]}.
- R8: A RAM write in wide mode gives exactly one write strobe pulse, with the whole word on the data bus.
- R9: A write request whose target is the ROM produces no write strobe pulse and no data drive. It still completes with done after 5 clocks.
- R10: ROM accesses are 16-bit in both modes: byte select stays 0 and done comes after 5 clocks.
- R11: A request presented in the clock right after done is accepted at once. Its done follows 6 clocks after the previous done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ram_narrow | input | 1 | Static RAM width mode: 1 = 8-bit, 0 = 16-bit |
| req_valid | input | 1 | Request present; held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ram | input | 1 | Target: 1 = RAM, 0 = ROM |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write word |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read word, valid with done |
| mem_addr | output | 19 | External word address |
| mem_dq_out | output | 16 | Outgoing data bus value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Incoming data bus value |
| mem_rom_cs_n | output | 1 | ROM select, active low |
| mem_ram_cs_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_byte_sel | output | 1 | RAM byte select in narrow mode |

## Verification
The properties assume the mode input changes only while no access is running, and that a request stays held with stable fields from acceptance until done. The byte-select property relies on the first of these. The bench switches the mode only between transfers. It changes the request fields only at the falling edge where done is seen, or while idle. The memory model in the bench drives the input data bus only while the read strobe is low. It puts garbage on the upper byte in narrow mode, so that bits [15:8] are shown to be ignored.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STB_LO = 3'd2,
      ST_STB_HI = 3'd3,
      ST_DONE   = 3'd4
   } bus_state_e;

   function automatic logic in_strobe(input bus_state_e s);
      return (s == ST_STB_LO) || (s == ST_STB_HI);
   endfunction

endpackage

// File: rtl/shmem_seq.sv
module shmem_seq
   import shmem_pkg::*;
#(
   parameter int SETUP_CLKS  = 2,
   parameter int STROBE_CLKS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       narrow,
   output bus_state_e state,
   output logic       phase_last
);

   localparam int MAX_PH = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS;
   localparam int CNT_W  = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;
   localparam logic [CNT_W-1:0] SETUP_END  = CNT_W'(SETUP_CLKS - 1);
   localparam logic [CNT_W-1:0] STROBE_END = CNT_W'(STROBE_CLKS - 1);

   logic [CNT_W-1:0] cnt;
   bus_state_e       state_nx;
   logic [CNT_W-1:0] cnt_nx;

   always_comb begin
      case (state)
         ST_SETUP:  phase_last = (cnt == SETUP_END);
         ST_STB_LO,
         ST_STB_HI: phase_last = (cnt == STROBE_END);
         default:   phase_last = 1'b1;
      endcase
   end

   always_comb begin
      state_nx = state;
      cnt_nx   = cnt;
      case (state)
         ST_IDLE: begin
            cnt_nx = '0;
            if (start) state_nx = ST_SETUP;
         end
         ST_SETUP: begin
            if (phase_last) begin
               state_nx = ST_STB_LO;
               cnt_nx   = '0;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_STB_LO: begin
            if (phase_last) begin
               state_nx = narrow ? ST_STB_HI : ST_DONE;
               cnt_nx   = '0;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_STB_HI: begin
            if (phase_last) begin
               state_nx = ST_DONE;
               cnt_nx   = '0;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_DONE: begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
         end
         default: begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         state <= state_nx;
         cnt   <= cnt_nx;
      end
   end

endmodule

// File: rtl/shmem_strobe.sv
module shmem_strobe
   import shmem_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  bus_state_e        state,
   input  logic              phase_last,
   input  logic              write_q,
   input  logic              ram_q,
   input  logic              narrow_q,
   input  logic [DATA_W-1:0] wdata_q,
   output logic              rom_cs_n,
   output logic              ram_cs_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              byte_sel,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   localparam int HALF_W = DATA_W / 2;

   logic busy;
   logic strobing;
   logic wr_ok;
   logic we_slot;

   assign busy     = (state != ST_IDLE);
   assign strobing = in_strobe(state);
   assign wr_ok    = write_q && ram_q;
   // narrow writes pulse only in the last clock of each byte phase
   assign we_slot  = narrow_q ? phase_last : 1'b1;

   assign rom_cs_n = !(busy && !ram_q);
   assign ram_cs_n = !(busy && ram_q);
   assign oe_n     = !(strobing && !write_q);
   assign we_n     = !(strobing && wr_ok && we_slot);
   assign dq_oe    = strobing && wr_ok;
   assign byte_sel = narrow_q && (state == ST_STB_HI);

   always_comb begin
      if (!narrow_q)
         dq_out = wdata_q;
      else if (state == ST_STB_HI)
         dq_out = {{(DATA_W-HALF_W){1'b0}}, wdata_q[DATA_W-1:HALF_W]};
      else
         dq_out = {{(DATA_W-HALF_W){1'b0}}, wdata_q[HALF_W-1:0]};
   end

endmodule

// File: rtl/shmem_rdcap.sv
module shmem_rdcap
   import shmem_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_state_e        state,
   input  logic              phase_last,
   input  logic              read_q,
   input  logic              narrow_q,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rdata
);

   localparam int HALF_W = DATA_W / 2;

   logic cap_lo;
   logic cap_hi;

   assign cap_lo = read_q && phase_last && (state == ST_STB_LO);
   assign cap_hi = read_q && phase_last && (state == ST_STB_HI);

   generate
      if (NARROW_EN) begin : g_split
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata <= '0;
            end else if (cap_lo) begin
               if (narrow_q)
                  rdata[HALF_W-1:0] <= dq_in[HALF_W-1:0];
               else
                  rdata <= dq_in;
            end else if (cap_hi) begin
               rdata[DATA_W-1:HALF_W] <= dq_in[HALF_W-1:0];
            end
         end
      end else begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rdata <= '0;
            else if (cap_lo)
               rdata <= dq_in;
         end
      end
   endgenerate

endmodule

// File: rtl/shmem_bus_ctrl.sv
module shmem_bus_ctrl
   import shmem_pkg::*;
#(
   parameter int ADDR_W       = 19,
   parameter int DATA_W       = 16,
   parameter int SETUP_CLKS   = 2,
   parameter int STROBE_CLKS  = 2,
   parameter bit NARROW_EN    = 1'b1,
   parameter int CLK_PS       = 26042,
   parameter int MIN_SETUP_PS = 45000,
   parameter int MIN_CYCLE_PS = 130000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ram_narrow,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_ram,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_rom_cs_n,
   output logic              mem_ram_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_byte_sel
);

   localparam int WIDE_CLKS = SETUP_CLKS + STROBE_CLKS + 1;

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("shmem_bus_ctrl: DATA_W must be even and at least 2");
      end
      if (SETUP_CLKS < 1 || STROBE_CLKS < 2) begin : g_bad_phase
         $error("shmem_bus_ctrl: SETUP_CLKS >= 1 and STROBE_CLKS >= 2 needed");
      end
      if (SETUP_CLKS * CLK_PS < MIN_SETUP_PS) begin : g_bad_setup
         $error("shmem_bus_ctrl: select-to-strobe setup too short");
      end
      if (WIDE_CLKS * CLK_PS < MIN_CYCLE_PS) begin : g_bad_cycle
         $error("shmem_bus_ctrl: word cycle too short");
      end
   endgenerate

   bus_state_e        state;
   logic              phase_last;
   logic              start;
   logic              write_q;
   logic              ram_q;
   logic              narrow_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              narrow_req;

   generate
      if (NARROW_EN) begin : g_narrow_on
         assign narrow_req = ram_narrow && req_ram;
      end else begin : g_narrow_off
         assign narrow_req = 1'b0;
      end
   endgenerate

   assign start = (state == ST_IDLE) && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q  <= 1'b0;
         ram_q    <= 1'b0;
         narrow_q <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
      end else if (start) begin
         write_q  <= req_write;
         ram_q    <= req_ram;
         narrow_q <= narrow_req;
         addr_q   <= req_addr;
         wdata_q  <= req_wdata;
      end
   end

   shmem_seq #(
      .SETUP_CLKS (SETUP_CLKS),
      .STROBE_CLKS(STROBE_CLKS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .narrow    (narrow_q),
      .state     (state),
      .phase_last(phase_last)
   );

   shmem_strobe #(
      .DATA_W(DATA_W)
   ) u_strobe (
      .state     (state),
      .phase_last(phase_last),
      .write_q   (write_q),
      .ram_q     (ram_q),
      .narrow_q  (narrow_q),
      .wdata_q   (wdata_q),
      .rom_cs_n  (mem_rom_cs_n),
      .ram_cs_n  (mem_ram_cs_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .byte_sel  (mem_byte_sel),
      .dq_out    (mem_dq_out),
      .dq_oe     (mem_dq_oe)
   );

   shmem_rdcap #(
      .DATA_W   (DATA_W),
      .NARROW_EN(NARROW_EN)
   ) u_rdcap (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .phase_last(phase_last),
      .read_q    (!write_q),
      .narrow_q  (narrow_q),
      .dq_in     (mem_dq_in),
      .rdata     (rsp_rdata)
   );

   assign mem_addr = addr_q;
   assign rsp_done = (state == ST_DONE);

endmodule

// File: rtl/shmem_bus_ctrl_chk.sv
module shmem_bus_ctrl_chk #(
   parameter int ADDR_W     = 19,
   parameter int SETUP_CLKS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ram_narrow,
   input logic              rsp_done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_dq_oe,
   input logic              mem_rom_cs_n,
   input logic              mem_ram_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_byte_sel
);

   logic       sel_any;
   logic [7:0] sel_cnt;

   assign sel_any = !mem_rom_cs_n || !mem_ram_cs_n;

   // clocks for which a select has been low, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_cnt <= '0;
      else if (!sel_any)
         sel_cnt <= '0;
      else if (sel_cnt != 8'hFF)
         sel_cnt <= sel_cnt + 8'd1;
   end

   p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   p_strobe_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_oe_n) || $fell(mem_we_n)) |-> (sel_any && sel_cnt >= 8'(SETUP_CLKS)));

   p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_rom_cs_n && !mem_ram_cs_n));

   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_any && $past(sel_any)) |-> $stable(mem_addr));

   p_drive_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && !mem_ram_cs_n));

   p_release_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (!mem_dq_oe && sel_any));

   p_rom_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rom_cs_n |-> mem_we_n);

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   p_byte_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_byte_sel |-> (!mem_ram_cs_n && ram_narrow));

endmodule

bind shmem_bus_ctrl shmem_bus_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .SETUP_CLKS(SETUP_CLKS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ram_narrow  (ram_narrow),
   .rsp_done    (rsp_done),
   .mem_addr    (mem_addr),
   .mem_dq_oe   (mem_dq_oe),
   .mem_rom_cs_n(mem_rom_cs_n),
   .mem_ram_cs_n(mem_ram_cs_n),
   .mem_oe_n    (mem_oe_n),
   .mem_we_n    (mem_we_n),
   .mem_byte_sel(mem_byte_sel)
);

// File: tb/sim_shmem_bus_ctrl.sv
`timescale 1ns/1ps
module sim_shmem_bus_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ram_narrow = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_ram = 1'b0;
   logic [18:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic [18:0] mem_addr;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in;
   logic        mem_rom_cs_n, mem_ram_cs_n, mem_oe_n, mem_we_n, mem_byte_sel;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   shmem_bus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ram_narrow(ram_narrow),
      .req_valid(req_valid), .req_write(req_write), .req_ram(req_ram),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in),
      .mem_rom_cs_n(mem_rom_cs_n), .mem_ram_cs_n(mem_ram_cs_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_byte_sel(mem_byte_sel)
   );

   // ---------------- memory model ----------------
   logic [15:0] ram16 [0:255];
   logic [7:0]  ram8  [0:511];

   function automatic logic [15:0] rom_word(input logic [18:0] a);
      return a[15:0] * 16'h0135 ^ 16'h5A3C ^ {13'd0, a[18:16]};
   endfunction

   always @* begin
      mem_dq_in = 16'hDEAD;
      if (!mem_oe_n) begin
         if (!mem_rom_cs_n)
            mem_dq_in = rom_word(mem_addr);
         else if (!mem_ram_cs_n)
            mem_dq_in = ram_narrow ? {8'hEE, ram8[{mem_addr[7:0], mem_byte_sel}]}
                                   : ram16[mem_addr[7:0]];
      end
   end

   // ---------------- bus monitor ----------------
   int          we_cnt = 0;
   logic        we_bs [0:3];
   logic [15:0] we_dq [0:3];
   bit          bs_seen = 0;
   bit          dqoe_seen = 0;
   logic        prev_we = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_we_n && !mem_ram_cs_n) begin
            if (ram_narrow) ram8[{mem_addr[7:0], mem_byte_sel}] = mem_dq_out[7:0];
            else            ram16[mem_addr[7:0]] = mem_dq_out;
         end
         if (prev_we && !mem_we_n) begin
            if (we_cnt < 4) begin
               we_bs[we_cnt] = mem_byte_sel;
               we_dq[we_cnt] = mem_dq_out;
            end
            we_cnt = we_cnt + 1;
         end
         if (mem_dq_oe)    dqoe_seen = 1;
         if (mem_byte_sel) bs_seen = 1;
      end
      prev_we = mem_we_n;
   end

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   logic [16:0] exp_q [$];
   string       tag_q [$];
   logic [15:0] shadow [0:255];

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         chk((!mem_dq_oe) && (!mem_rom_cs_n || !mem_ram_cs_n), "R5 release",
             {30'd0, mem_dq_oe, mem_rom_cs_n & mem_ram_cs_n}, 32'd0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected done", 32'd1, 32'd0);
         end else begin
            logic [16:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e[16]) chk(rsp_rdata == e[15:0], t, {16'd0, rsp_rdata}, {16'd0, e[15:0]});
         end
      end
   end

   task automatic xfer(input bit wr, input bit ram, input logic [18:0] a,
                       input logic [15:0] wd, input int exp_lat, input string tag);
      int n;
      logic [15:0] e;
      we_cnt    = 0;
      bs_seen   = 0;
      dqoe_seen = 0;
      e = ram ? shadow[a[7:0]] : rom_word(a);
      exp_q.push_back({!wr, e});
      tag_q.push_back(tag);
      req_write = wr;
      req_ram   = ram;
      req_addr  = a;
      req_wdata = wd;
      req_valid = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!rsp_done && n < 60);
      req_valid = 1'b0;
      chk(n == exp_lat, {tag, " latency"}, n, exp_lat);
      if (wr && ram) begin
         shadow[a[7:0]] = wd;
         if (ram_narrow) begin
            chk(we_cnt == 2, "R7 pulse count", we_cnt, 2);
            if (we_cnt == 2) begin
               chk(we_bs[0] == 1'b0 && we_dq[0] == {8'h00, wd[7:0]}, "R7 low byte",
                   {15'd0, we_bs[0], we_dq[0]}, {16'd0, 8'h00, wd[7:0]});
               chk(we_bs[1] == 1'b1 && we_dq[1] == {8'h00, wd[15:8]}, "R7 high byte",
                   {15'd0, we_bs[1], we_dq[1]}, {15'd1, 8'h00, wd[15:8]});
            end
         end else begin
            chk(we_cnt == 1, "R8 pulse count", we_cnt, 1);
            if (we_cnt >= 1) chk(we_dq[0] == wd, "R8 data", we_dq[0], wd);
         end
      end
      if (wr && !ram) begin
         chk(we_cnt == 0, "R9 no write strobe", we_cnt, 0);
         chk(dqoe_seen == 0, "R9 no drive", dqoe_seen, 0);
      end
      if (!ram) chk(bs_seen == 0, "R10 byte select", bs_seen, 0);
   endtask

   // watchdog
   initial begin
      #400000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         ram16[i]  = 16'h3C00 ^ 16'(i);
         shadow[i] = 16'h3C00 ^ 16'(i);
      end
      for (int i = 0; i < 512; i++) ram8[i] = 8'(i);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mem_rom_cs_n && mem_ram_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe &&
          !mem_byte_sel && !rsp_done, "R1 in reset",
          {25'd0, mem_rom_cs_n, mem_ram_cs_n, mem_oe_n, mem_we_n, mem_dq_oe,
           mem_byte_sel, rsp_done}, 32'h78);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_rom_cs_n && mem_ram_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe &&
          !mem_byte_sel && !rsp_done, "R1 after reset",
          {25'd0, mem_rom_cs_n, mem_ram_cs_n, mem_oe_n, mem_we_n, mem_dq_oe,
           mem_byte_sel, rsp_done}, 32'h78);

      // wide mode
      ram_narrow = 1'b0;
      xfer(0, 0, 19'h00005, 16'h0, 5, "R2 rom read");
      @(negedge clk);
      xfer(0, 0, 19'h7FFFF, 16'h0, 5, "R3 rom read top address");
      @(negedge clk);
      xfer(1, 1, 19'h00003, 16'hBEEF, 5, "R8 ram write");
      @(negedge clk);
      xfer(0, 1, 19'h00003, 16'h0, 5, "R2 ram read");
      @(negedge clk);
      xfer(1, 0, 19'h00020, 16'hFFFF, 5, "R9 rom write");
      @(negedge clk);
      xfer(0, 1, 19'h00020, 16'h0, 5, "R9 ram untouched");
      @(negedge clk);
      xfer(1, 1, 19'h0000A, 16'h5AA5, 5, "R11 first");
      xfer(0, 1, 19'h0000A, 16'h0, 6, "R11 back to back");
      xfer(0, 0, 19'h00011, 16'h0, 6, "R11 back to back rom");
      @(negedge clk);

      // narrow mode
      ram_narrow = 1'b1;
      @(negedge clk);
      xfer(1, 1, 19'h00007, 16'h12A5, 7, "R7 narrow write");
      @(negedge clk);
      xfer(0, 1, 19'h00007, 16'h0, 7, "R6 narrow read");
      @(negedge clk);
      xfer(0, 0, 19'h00040, 16'h0, 5, "R10 rom read narrow mode");
      @(negedge clk);
      xfer(1, 1, 19'h7FF01, 16'hFF00, 7, "R7 narrow write top");
      xfer(0, 1, 19'h7FF01, 16'h0, 8, "R6 narrow read back to back");
      @(negedge clk);
      xfer(1, 0, 19'h00007, 16'h0000, 5, "R9 rom write narrow");
      @(negedge clk);
      xfer(0, 1, 19'h00007, 16'h0, 7, "R9 narrow ram untouched");
      repeat (3) @(negedge clk);

      chk(exp_q.size() == 0, "R2 all responses", exp_q.size(), 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule